// File: doc/BRIEF.md
# SD Command-Line Short-Response Receiver

After a host controller has sent a command to an SD card, this block takes over the command line to collect the card's short reply. It drives the line high, generates the card clock, and polls for a response start bit (a 0). It gives up after a bounded number of polls. Once the start bit is seen, it clocks past the remaining seven header bits. It then shifts in the sixteen bits that follow, most significant first, and keeps them as two bytes. The rest of the reply is never interpreted.

After capture, the block keeps clocking the card with the line high for a fixed flush run. It then raises a one-cycle completion pulse together with a success flag. On a timeout it stops clocking at once and reports failure, and the previously captured bytes stay untouched. The incoming line passes through a two-flop synchronizer. It is sampled in the last system cycle of each card-clock low phase, and the card clock then rises.

Top module: `sd_resp_capture`

## Requirements
- R1: While reset is asserted, and until the first accepted start, busy, done, resp_ok, resp_timeout, card_clk and cmd_hi_en are 0, and resp_hi and resp_lo are 0x00.
- R2: A start pulse is accepted only when busy is 0; busy is 1 from the cycle after acceptance. A start seen while busy is 1, including on the finishing cycle, has no effect on the run in progress.
- R3: While busy, card_clk has a period of 2*HALF system cycles (default 8). It is low for the first HALF cycles of each period, counted from acceptance, and high for the rest. cmd_hi_en (drive the line high) is 1 exactly while busy. card_clk is 0 whenever busy is 0.
- R4: Card-clock period p (counted from 0) polls the line. The first period whose sample is 0, within the first POLL_MAX (default 255) periods, holds the start bit.
- R5: If POLL_MAX polls all sample 1, the run ends at the end of the last polling period with done=1 and resp_timeout=1. No trailing clocks are issued, resp_ok stays 0, and resp_hi and resp_lo keep their previous values.
- R6: The SKIP_BITS (default 7) card-clock periods after the start bit are clocked but not stored, whatever their values.
- R7: The next 16 sampled bits are captured MSB-first. The first 8 form resp_hi (first bit in bit 7) and the next 8 form resp_lo. Both outputs change only on a successful finish.
- R8: After capture, FLUSH_CLKS (default 256) further card-clock periods are issued, and line values during them are ignored. The run then ends with done=1 and resp_ok=1. A successful run therefore lasts (s+1+SKIP_BITS+16+FLUSH_CLKS)*2*HALF cycles, where s is the start-bit period.
- R9: done is a one-cycle pulse in the cycle busy falls. resp_ok and resp_timeout are never both 1; they hold until the next accepted start, which clears both.
- R10: cmd_in is passed through two flip-flops and sampled in the last cycle of each low phase. A bit the card changes at the start of a low phase is therefore the one seen for that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin waiting for a response (accepted when idle) |
| cmd_in | input | 1 | Command line as seen from the card |
| card_clk | output | 1 | Clock to the card |
| cmd_hi_en | output | 1 | Drive the command line high |
| busy | output | 1 | A response run is in progress |
| done | output | 1 | One-cycle completion pulse |
| resp_ok | output | 1 | Last run captured a response |
| resp_timeout | output | 1 | Last run saw no start bit |
| resp_hi | output | 8 | First captured response byte |
| resp_lo | output | 8 | Second captured response byte |

## Verification
The checker watches several rules on every cycle:
- card_clk stays quiet when idle, and each high phase lasts at least two cycles.
- A start is taken only from idle.
- done is a single pulse that coincides with busy falling, and the two result flags never coexist.
- The result bytes move only at a successful finish, and the flags are cleared when a run begins.

Only the bench's scenarios can show the rest: the exact card-clock count of each run, where the start bit is found (first poll, a middle poll, the very last poll), and that zeros in the header and garbage after the data are ignored. They also show the MSB-first byte alignment through the synchronizer and the timeout case that holds the old bytes.

// File: rtl/sd_resp_capture.sv
module sd_resp_capture #(
  parameter int HALF       = 4,
  parameter int POLL_MAX   = 255,
  parameter int SKIP_BITS  = 7,
  parameter int FLUSH_CLKS = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cmd_in,
  output logic       card_clk,
  output logic       cmd_hi_en,
  output logic       busy,
  output logic       done,
  output logic       resp_ok,
  output logic       resp_timeout,
  output logic [7:0] resp_hi,
  output logic [7:0] resp_lo
);

  localparam int CAP_BITS = 16;
  localparam int PH_W     = $clog2(2 * HALF);
  localparam int CNT_MAX  = (POLL_MAX > FLUSH_CLKS) ? POLL_MAX : FLUSH_CLKS;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SKIP, S_CAP, S_FLUSH} st_t;

  st_t                 st;
  logic [PH_W-1:0]     ph;
  logic [CNT_W-1:0]    cnt;
  logic                sync1, sync2, smp;
  logic [CAP_BITS-1:0] sreg;
  int                  lim;

  wire bit_end = (ph == PH_W'(2 * HALF - 1));
  wire smp_pt  = (ph == PH_W'(HALF - 1));
  wire last    = (32'(cnt) == lim - 1);

  assign busy      = (st != S_IDLE);
  assign cmd_hi_en = busy;
  assign card_clk  = busy && (ph >= PH_W'(HALF));

  always_comb begin
    case (st)
      S_WAIT:  lim = POLL_MAX;
      S_SKIP:  lim = SKIP_BITS;
      S_CAP:   lim = CAP_BITS;
      S_FLUSH: lim = FLUSH_CLKS;
      default: lim = 1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
    end else begin
      sync1 <= cmd_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      ph           <= '0;
      cnt          <= '0;
      smp          <= 1'b1;
      sreg         <= '0;
      done         <= 1'b0;
      resp_ok      <= 1'b0;
      resp_timeout <= 1'b0;
      resp_hi      <= '0;
      resp_lo      <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        ph  <= '0;
        cnt <= '0;
        if (start) begin
          st           <= S_WAIT;
          resp_ok      <= 1'b0;
          resp_timeout <= 1'b0;
        end
      end else begin
        ph <= bit_end ? '0 : ph + 1'b1;
        if (smp_pt) smp <= sync2;
        if (bit_end) begin
          case (st)
            S_WAIT: begin
              if (!smp) begin
                st  <= S_SKIP;
                cnt <= '0;
              end else if (last) begin
                st           <= S_IDLE;
                done         <= 1'b1;
                resp_timeout <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            S_SKIP: begin
              if (last) begin
                st  <= S_CAP;
                cnt <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            S_CAP: begin
              sreg <= {sreg[CAP_BITS-2:0], smp};
              if (last) begin
                st  <= S_FLUSH;
                cnt <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            S_FLUSH: begin
              if (last) begin
                st      <= S_IDLE;
                done    <= 1'b1;
                resp_ok <= 1'b1;
                resp_hi <= sreg[15:8];
                resp_lo <= sreg[7:0];
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/sd_resp_capture_chk.sv
module sd_resp_capture_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       card_clk,
  input logic       busy,
  input logic       done,
  input logic       resp_ok,
  input logic       resp_timeout,
  input logic [7:0] resp_hi,
  input logic [7:0] resp_lo
);

  assert_idle_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !card_clk);

  assert_clk_high_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_clk) |=> card_clk);

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_ok && resp_timeout));

  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!resp_ok && !resp_timeout));

  assert_bytes_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && resp_ok) |-> ($stable(resp_hi) && $stable(resp_lo)));

endmodule

bind sd_resp_capture sd_resp_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .card_clk(card_clk), .busy(busy),
  .done(done), .resp_ok(resp_ok), .resp_timeout(resp_timeout),
  .resp_hi(resp_hi), .resp_lo(resp_lo)
);

// File: tb/test_sd_resp_capture.sv
`timescale 1ns/1ps
module test_sd_resp_capture;
  localparam int HALF = 4;
  localparam int PER  = 2 * HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmd_in = 1'b1;
  logic card_clk, cmd_hi_en, busy, done, resp_ok, resp_timeout;
  logic [7:0] resp_hi, resp_lo;

  always #2.5 clk = ~clk;

  sd_resp_capture i_sd_resp_capture (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_in(cmd_in),
    .card_clk(card_clk), .cmd_hi_en(cmd_hi_en), .busy(busy), .done(done),
    .resp_ok(resp_ok), .resp_timeout(resp_timeout),
    .resp_hi(resp_hi), .resp_lo(resp_lo)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  logic [0:1023] sbits;
  bit m_act = 0, e_done = 0, e_ok = 0, e_to = 0, m_okrun = 0;
  int j = 0, tot = 0;
  logic [7:0] e_hi = 0, e_lo = 0, m_hi = 0, m_lo = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic plan_run();
    int s;
    s = -1;
    for (int k = 0; k < 255; k++) if (s < 0 && sbits[k] == 1'b0) s = k;
    if (s < 0) begin
      tot = 255; m_okrun = 0;
    end else begin
      tot = s + 1 + 7 + 16 + 256; m_okrun = 1;
      for (int b = 0; b < 8; b++) begin
        m_hi[7-b] = sbits[s+8+b];
        m_lo[7-b] = sbits[s+16+b];
      end
    end
  endtask

  task automatic step(input bit st);
    bit was;
    @(negedge clk);
    chk("R2 busy", busy, m_act);
    chk("R3 card_clk", card_clk, m_act && ((j % PER) >= HALF));
    chk("R3 cmd_hi_en", cmd_hi_en, m_act);
    chk("R9 done", done, e_done);
    chk("R4 R8 resp_ok", resp_ok, e_ok);
    chk("R5 resp_timeout", resp_timeout, e_to);
    chk("R7 R6 R10 resp_hi", resp_hi, e_hi);
    chk("R7 R6 R10 resp_lo", resp_lo, e_lo);
    start = st;
    cmd_in = m_act ? sbits[j / PER] : 1'b1;
    was = m_act;
    e_done = 0;
    if (m_act) begin
      j++;
      if (j == tot * PER) begin
        m_act = 0; e_done = 1;
        if (m_okrun) begin e_ok = 1; e_hi = m_hi; e_lo = m_lo; end
        else e_to = 1;
      end
    end
    if (!was && st) begin
      m_act = 1; j = 0; e_ok = 0; e_to = 0; plan_run();
    end
  endtask

  task automatic load(input int s, input logic [6:0] hdr, input logic [15:0] dat,
                      input bit junk);
    for (int k = 0; k < 1024; k++) sbits[k] = junk ? k[0] : 1'b1;
    for (int k = 0; k < s; k++) sbits[k] = 1'b1;
    if (s < 1000) begin
      sbits[s] = 1'b0;
      for (int b = 0; b < 7; b++) sbits[s+1+b] = hdr[6-b];
      for (int b = 0; b < 16; b++) sbits[s+8+b] = dat[15-b];
    end
  endtask

  task automatic run(input bit hold_start);
    step(1'b1);
    while (m_act) step(hold_start);
    step(1'b0);
    while (m_act) step(1'b0);
    for (int k = 0; k < 3; k++) step(1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 resp_ok", resp_ok, 0);
    chk("R1 resp_timeout", resp_timeout, 0);
    chk("R1 card_clk", card_clk, 0);
    chk("R1 cmd_hi_en", cmd_hi_en, 0);
    chk("R1 resp_hi", resp_hi, 0);
    chk("R1 resp_lo", resp_lo, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step(1'b0);

    load(0, 7'b0000000, 16'hA53C, 1'b0);   run(1'b0);
    chk("R7 hi after first poll start", resp_hi, 8'hA5);
    load(37, 7'b0101010, 16'h0FF0, 1'b1);  run(1'b0);
    chk("R6 lo with zero header bits", resp_lo, 8'hF0);
    load(254, 7'b1111111, 16'h8001, 1'b1); run(1'b0);
    chk("R4 start on last poll", resp_ok, 1);
    load(2000, 7'b0, 16'h0, 1'b0);         run(1'b0);
    chk("R5 timeout flag", resp_timeout, 1);
    chk("R5 bytes held", {resp_hi, resp_lo}, 16'h8001);
    load(5, 7'b0011001, 16'h1234, 1'b1);   run(1'b1);
    chk("R2 start held during run", {resp_hi, resp_lo}, 16'h1234);
    load(1, 7'b1000000, 16'hFFFF, 1'b0);   run(1'b0);
    chk("R10 all-ones data", {resp_hi, resp_lo}, 16'hFFFF);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule